// File: doc/BRIEF.md
# Sibling Page Consolidation Engine

This engine decides when a pair of sibling pages can be merged into one: a primary page and the alternate page assigned next to it, with every line's committed copy held in exactly one of the two. For each tracked pair it keeps a reference count. The count goes up on every translation fill that fetches the pair's metadata and down on every eviction of such an entry. A pair can be merged only when nothing references it and no commit log for it is still pending.

A merge is requested with the pair index and the pair's committed vector. Bit i of that vector is 1 when line i's committed copy lives in the primary page and 0 when it lives in the alternate page. The engine counts the committed lines on each side and picks the side with more as the destination; on a tie the primary page is kept. It then issues one line-move command per line that must migrate, in ascending line order. Only after the last move has been accepted does it return the new committed vector and name the page that was freed.

All three handshakes follow valid/ready rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A move command or a response, once raised, keeps its valid and payload unchanged until the matching ready is seen high at a clock edge. Back-pressure on the move port stretches the merge; back-pressure on the response port keeps the engine busy and holds off the next request.

Top module: `sibling_merge_engine`

## Requirements
- R1: Each cycle with `fill_valid` high adds one to the reference count of `fill_page` (saturating at the count's maximum); a pair with a nonzero count is refused.
- R2: Each cycle with `evict_valid` high subtracts one from the count of `evict_page`; a fill and an eviction of the same pair in one cycle leave its count unchanged.
- R3: A request for a pair whose count is nonzero, as held when the request is accepted, is refused with status 1. No move is issued, `rsp_free_alt` is 0 and `rsp_cvec` echoes the request's vector.
- R4: A request for a pair with zero references whose `log_pending` bit is high is refused with status 2, with the same response fields as R3. When both conditions hold, status 1 wins.
- R5: When the primary side's committed-line count is at least the alternate side's, the primary page is kept. Every line whose vector bit is 0 is moved with `cp_to_alt` = 0, and the response has `rsp_free_alt` = 1 and `rsp_cvec` all ones.
- R6: Otherwise the alternate page is kept. Every line whose vector bit is 1 is moved with `cp_to_alt` = 1, and the response has `rsp_free_alt` = 0 and `rsp_cvec` all zeros.
- R7: Move commands appear in ascending line order, one per accepted handshake. A stalled command keeps its line and direction stable.
- R8: The response with status 0 is raised only after the last move has been accepted, and never in the same cycle as a move command.
- R9: An eviction of a pair whose count is zero, with no fill of that pair in the same cycle, raises `underflow_err` for exactly one cycle, the cycle after; the count stays zero.
- R10: `req_ready` is high only when no merge or response is in progress. A raised response holds all its fields until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | A translation fill fetched a pair's metadata |
| fill_page | input | PW | Pair index of the fill |
| evict_valid | input | 1 | A translation entry was evicted |
| evict_page | input | PW | Pair index of the eviction |
| underflow_err | output | 1 | One-cycle pulse: eviction of a pair with zero references |
| log_pending | input | NUM_PAGES | Per pair: a commit log is still outstanding |
| req_valid | input | 1 | Merge request valid |
| req_ready | output | 1 | Engine can take a request |
| req_page | input | PW | Pair index to merge |
| req_cvec | input | LINES | Committed vector, 1 = line committed in primary |
| cp_valid | output | 1 | Line-move command valid |
| cp_ready | input | 1 | Memory port accepts the move |
| cp_page | output | PW | Pair index of the move |
| cp_line | output | LW | Line index to move |
| cp_to_alt | output | 1 | 1 = primary to alternate, 0 = alternate to primary |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_status | output | 2 | 0 merged, 1 referenced, 2 log pending |
| rsp_page | output | PW | Pair index of the response |
| rsp_free_alt | output | 1 | 1 = alternate page freed, 0 = primary freed (status 0) |
| rsp_cvec | output | LINES | Resulting committed vector |

## Verification
The bench attacks the tie between equal line counts: a design that compares with strict inequality would move the primary's lines the other way and free the wrong page. It fills and evicts the same pair in one cycle and evicts at zero. A count that wrapped instead of holding at zero would then refuse every later merge, and a missing pulse would hide the underflow. It throttles both ready inputs pseudo-randomly. A design that skipped a line on a stalled handshake, changed the line while stalled, or answered before the final move would diverge from the reference model on that clock. Merges with nothing to move, and requests refused for references or logs, show whether the vector is touched at all when it must not be.

// File: rtl/sme_pkg.sv
package sme_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MOVE  = 2'd1,
    ST_REPLY = 2'd2
  } sme_state_t;

  typedef enum logic [1:0] {
    RS_MERGED = 2'd0,
    RS_REFD   = 2'd1,
    RS_LOG    = 2'd2
  } sme_status_t;
endpackage

// File: rtl/sme_refcount.sv
module sme_refcount #(
  parameter int NUM_PAGES = 4,
  parameter int REF_W     = 3,
  localparam int PW       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  input  logic [PW-1:0]        fill_page,
  input  logic                 evict_valid,
  input  logic [PW-1:0]        evict_page,
  output logic [NUM_PAGES-1:0] idle_pages,
  output logic                 underflow_err
);
  localparam logic [REF_W-1:0] CNT_MAX = '1;

  logic [NUM_PAGES-1:0] uf_hit;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic [REF_W-1:0] cnt;
    logic inc, dec;
    assign inc = fill_valid  && (fill_page  == PW'(g));
    assign dec = evict_valid && (evict_page == PW'(g));
    assign idle_pages[g] = (cnt == '0);
    assign uf_hit[g] = dec && !inc && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (inc && !dec) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else if (dec && !inc) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow_err <= 1'b0;
    else        underflow_err <= |uf_hit;
  end
endmodule

// File: rtl/sme_popcount.sv
module sme_popcount #(
  parameter int LINES = 8,
  localparam int CW   = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0] vec,
  output logic [CW-1:0]    count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < LINES; k++) count = count + CW'(vec[k]);
  end
endmodule

// File: rtl/sme_lowest.sv
module sme_lowest #(
  parameter int LINES = 8,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] mask,
  output logic [LW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (mask[k]) idx = LW'(k);
    end
  end
endmodule

// File: rtl/sibling_merge_engine.sv
module sibling_merge_engine
  import sme_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int LINES     = 8,
  parameter int REF_W     = 3,
  localparam int PW       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int LW       = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  input  logic [PW-1:0]        fill_page,
  input  logic                 evict_valid,
  input  logic [PW-1:0]        evict_page,
  output logic                 underflow_err,
  input  logic [NUM_PAGES-1:0] log_pending,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PW-1:0]        req_page,
  input  logic [LINES-1:0]     req_cvec,
  output logic                 cp_valid,
  input  logic                 cp_ready,
  output logic [PW-1:0]        cp_page,
  output logic [LW-1:0]        cp_line,
  output logic                 cp_to_alt,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_status,
  output logic [PW-1:0]        rsp_page,
  output logic                 rsp_free_alt,
  output logic [LINES-1:0]     rsp_cvec
);
  localparam int CW = $clog2(LINES + 1);

  sme_state_t           state;
  logic [LINES-1:0]     move_mask;
  logic [PW-1:0]        cur_page;
  logic                 keep_pri_q;
  sme_status_t          status_q;
  logic [LINES-1:0]     cvec_q;
  logic [NUM_PAGES-1:0] idle_pages;
  logic [CW-1:0]        pri_count;
  logic                 keep_pri;
  logic [LW-1:0]        next_line;

  sme_refcount #(.NUM_PAGES(NUM_PAGES), .REF_W(REF_W)) u_refs (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_valid   (fill_valid),
    .fill_page    (fill_page),
    .evict_valid  (evict_valid),
    .evict_page   (evict_page),
    .idle_pages   (idle_pages),
    .underflow_err(underflow_err)
  );

  sme_popcount #(.LINES(LINES)) u_pop (
    .vec  (req_cvec),
    .count(pri_count)
  );

  sme_lowest #(.LINES(LINES)) u_pick (
    .mask(move_mask),
    .idx (next_line)
  );

  // Primary is kept when its committed count is at least the alternate's.
  assign keep_pri = (2 * int'(pri_count)) >= LINES;

  assign req_ready    = (state == ST_IDLE);
  assign cp_valid     = (state == ST_MOVE) && (move_mask != '0);
  assign cp_page      = cur_page;
  assign cp_line      = next_line;
  assign cp_to_alt    = !keep_pri_q;
  assign rsp_valid    = (state == ST_REPLY);
  assign rsp_status   = status_q;
  assign rsp_page     = cur_page;
  assign rsp_free_alt = (status_q == RS_MERGED) && keep_pri_q;
  assign rsp_cvec     = cvec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      move_mask  <= '0;
      cur_page   <= '0;
      keep_pri_q <= 1'b1;
      status_q   <= RS_MERGED;
      cvec_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_page <= req_page;
            cvec_q   <= req_cvec;
            if (!idle_pages[req_page]) begin
              status_q <= RS_REFD;
              state    <= ST_REPLY;
            end else if (log_pending[req_page]) begin
              status_q <= RS_LOG;
              state    <= ST_REPLY;
            end else begin
              status_q   <= RS_MERGED;
              keep_pri_q <= keep_pri;
              move_mask  <= keep_pri ? ~req_cvec : req_cvec;
              state      <= ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (move_mask == '0) begin
            // Vector switch is the last step of the merge.
            cvec_q <= keep_pri_q ? '1 : '0;
            state  <= ST_REPLY;
          end else if (cp_ready) begin
            move_mask[next_line] <= 1'b0;
          end
        end
        ST_REPLY: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sme_checker.sv
module sme_checker #(
  parameter int PW    = 2,
  parameter int LW    = 3,
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evict_valid,
  input logic             underflow_err,
  input logic             req_ready,
  input logic             cp_valid,
  input logic             cp_ready,
  input logic [LW-1:0]    cp_line,
  input logic             cp_to_alt,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_status,
  input logic [PW-1:0]    rsp_page,
  input logic             rsp_free_alt,
  input logic [LINES-1:0] rsp_cvec
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || cp_valid) |-> !req_ready); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_page)
                                   && $stable(rsp_cvec) && $stable(rsp_free_alt))); // R10

  AST_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_ready) |=> (cp_valid && $stable(cp_line) && $stable(cp_to_alt))); // R7

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_valid && rsp_valid)); // R8

  AST_MERGED_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> (rsp_free_alt ? (rsp_cvec == '1) : (rsp_cvec == '0))); // R5

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> !rsp_free_alt); // R3

  AST_UF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_err) |-> $past(evict_valid)); // R9
endmodule

bind sibling_merge_engine sme_checker #(.PW(PW), .LW(LW), .LINES(LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evict_valid  (evict_valid),
  .underflow_err(underflow_err),
  .req_ready    (req_ready),
  .cp_valid     (cp_valid),
  .cp_ready     (cp_ready),
  .cp_line      (cp_line),
  .cp_to_alt    (cp_to_alt),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_status   (rsp_status),
  .rsp_page     (rsp_page),
  .rsp_free_alt (rsp_free_alt),
  .rsp_cvec     (rsp_cvec)
);

// File: tb/sibling_merge_engine_test.sv
module sibling_merge_engine_test;
  localparam int NP = 4;
  localparam int NL = 8;
  localparam int RW = 3;
  localparam int PW = 2;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 1'b0, evict_valid = 1'b0;
  logic [PW-1:0] fill_page = '0, evict_page = '0;
  logic [NP-1:0] log_pending = '0;
  logic req_valid = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic [NL-1:0] req_cvec = '0;
  logic cp_ready = 1'b1, rsp_ready = 1'b1;

  logic underflow_err, req_ready, cp_valid, cp_to_alt, rsp_valid, rsp_free_alt;
  logic [PW-1:0] cp_page, rsp_page;
  logic [LW-1:0] cp_line;
  logic [1:0] rsp_status;
  logic [NL-1:0] rsp_cvec;

  always #4 clk = ~clk;

  sibling_merge_engine #(.NUM_PAGES(NP), .LINES(NL), .REF_W(RW)) uut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_page(fill_page),
    .evict_valid(evict_valid), .evict_page(evict_page),
    .underflow_err(underflow_err), .log_pending(log_pending),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page), .req_cvec(req_cvec),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_page(cp_page), .cp_line(cp_line),
    .cp_to_alt(cp_to_alt), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_page(rsp_page), .rsp_free_alt(rsp_free_alt),
    .rsp_cvec(rsp_cvec)
  );

  // Behavioural reference model
  int m_state = 0;          // 0 idle, 1 moving, 2 replying
  int m_refs[NP];
  int m_moves[$];
  int m_status = 0, m_page = 0;
  bit m_to_alt = 1'b0, m_free_alt = 1'b0, m_uf = 1'b0;
  logic [NL-1:0] m_cvec = '0;
  bit started = 1'b0;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_state = 0; m_moves.delete(); m_uf = 0; m_status = 0; m_page = 0;
      m_free_alt = 0; m_to_alt = 0; m_cvec = '0;
      foreach (m_refs[i]) m_refs[i] = 0;
    end else begin
      case (m_state)
        0: if (req_valid) begin
          int ones;
          m_page = req_page;
          m_cvec = req_cvec;
          m_free_alt = 0;
          ones = $countones(req_cvec);
          if (m_refs[req_page] != 0) begin m_status = 1; m_state = 2; end
          else if (log_pending[req_page]) begin m_status = 2; m_state = 2; end
          else begin
            m_status = 0; m_state = 1;
            m_to_alt = (ones < NL - ones);
            for (int k = 0; k < NL; k++)
              if (req_cvec[k] == m_to_alt) m_moves.push_back(k);
          end
        end
        1: if (m_moves.size() == 0) begin
          m_state = 2;
          m_free_alt = !m_to_alt;
          m_cvec = m_to_alt ? '0 : '1;
        end else if (cp_ready) void'(m_moves.pop_front());
        default: if (rsp_ready) m_state = 0;
      endcase
      m_uf = 0;
      for (int p = 0; p < NP; p++) begin
        bit inc, dec;
        inc = fill_valid && fill_page == p;
        dec = evict_valid && evict_page == p;
        if (inc && !dec && m_refs[p] < (1 << RW) - 1) m_refs[p]++;
        if (dec && !inc) begin
          if (m_refs[p] == 0) m_uf = 1;
          else m_refs[p]--;
        end
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cycles++;
      cmp("R10 req_ready", req_ready, m_state == 0);
      cmp("R7 R8 cp_valid", cp_valid, m_state == 1 && m_moves.size() > 0);
      if (m_state == 1 && m_moves.size() > 0) begin
        cmp("R5 R6 R7 cp_line", cp_line, m_moves[0]);
        cmp("R5 R6 cp_to_alt", cp_to_alt, m_to_alt);
        cmp("R7 cp_page", cp_page, m_page);
      end
      cmp("R8 R10 rsp_valid", rsp_valid, m_state == 2);
      if (m_state == 2) begin
        cmp("R1 R2 R3 R4 rsp_status", rsp_status, m_status);
        cmp("R10 rsp_page", rsp_page, m_page);
        cmp("R5 R6 rsp_free_alt", rsp_free_alt, m_free_alt);
        cmp("R3 R5 R6 R8 rsp_cvec", rsp_cvec, m_cvec);
      end
      cmp("R9 underflow_err", underflow_err, m_uf);
    end
  end

  // Pseudo-random back-pressure
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cp_ready  = bp_on ? lfsr[0] : 1'b1;
    rsp_ready = bp_on ? lfsr[3] : 1'b1;
  end

  task automatic wait_idle();
    for (int k = 0; k < 300 && !(req_ready && m_state == 0); k++) @(negedge clk);
  endtask

  task automatic merge(int page, logic [NL-1:0] vec);
    wait_idle();
    req_valid = 1'b1; req_page = PW'(page); req_cvec = vec;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic touch(bit f, int fp, bit e, int ep);
    fill_valid = f; fill_page = PW'(fp); evict_valid = e; evict_page = PW'(ep);
    @(negedge clk);
    fill_valid = 1'b0; evict_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                            // reset state checked each clock (R10)
    @(negedge clk);
    merge(0, 8'b1011_0001);                  // R5 tie: keep primary
    merge(3, 8'b0000_0010);                  // R6 move line 1 to alternate
    merge(2, 8'hFF);                         // R5 nothing to move
    merge(1, 8'h00);                         // R6 nothing to move
    touch(1, 1, 0, 0); touch(1, 1, 0, 0);    // R1
    merge(1, 8'h0F);                         // R3 refused
    touch(0, 0, 1, 1);
    merge(1, 8'h0F);                         // R2 still one ref -> R3
    touch(0, 0, 1, 1);
    merge(1, 8'h0F);                         // R2 back to zero: merges
    log_pending = 4'b0100;
    merge(2, 8'h3C);                         // R4 refused
    touch(1, 2, 0, 0);
    merge(2, 8'h3C);                         // R4 both -> status 1
    touch(0, 0, 1, 2);
    log_pending = '0;
    touch(0, 0, 1, 0);                       // R9 underflow at zero
    touch(1, 3, 1, 3);                       // R2 same-cycle: no underflow
    merge(3, 8'h81);                         // count still zero
    bp_on = 1'b1;                            // R7 R10 back-pressure
    merge(0, 8'b0110_1010);
    merge(1, 8'b1000_0000);
    merge(2, 8'b1111_1110);
    for (int i = 0; i < 12; i++) merge(i % NP, NL'(i * 37 + 5));
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R10: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule